// File: doc/BRIEF.md
# Sequential Extended Divide Unit

This block carries out three register divide operations for a 16-bit processor core, one quotient bit per clock. A signed 16-by-16 divide takes D as the dividend and X as the divisor. It returns the quotient for X and the remainder for D. Two 32-by-16 forms, one unsigned and one signed, take the concatenation Y:D as the dividend, with Y as the high half, and X as the divisor. They return the quotient for Y and the remainder for D.

The core works on magnitudes with a restoring shift-subtract loop and applies the signs in one final cycle. The register file samples the operands when start is accepted. It then writes back whichever registers the unit enables in the cycle that done is high. The flags N, Z, V and C are presented in that same cycle. A zero divisor raises carry and leaves every register untouched.

Top module: `ext_divider`

## Requirements
- R1: Opcode 0 (signed 16/16) divides D by X as two's-complement values. The quotient is written to X and the remainder to D. The quotient truncates toward zero and a non-zero remainder has the sign of the dividend.
- R2: Opcode 1 (unsigned 32/16) divides the unsigned value {Y,D} by unsigned X. The low 16 bits of the quotient go to Y and the remainder goes to D.
- R3: Opcode 2 (signed 32/16) divides the two's-complement value {Y,D} by signed X. It uses the same truncation and remainder sign as R1, and writes the quotient's low 16 bits to Y and the remainder to D.
- R4: With X equal to zero, flagC is 1 at done and all of dWe, xWe, yWe and nzvWe are 0.
- R5: With X non-zero, flagC is 0 and nzvWe is 1 at done. flagZ is 1 exactly when the full quotient is zero, and flagN equals bit 15 of the written quotient.
- R6: For opcode 1, flagV is 1 exactly when the quotient exceeds 65535.
- R7: For opcodes 0 and 2, flagV is 1 exactly when the quotient lies outside -32768..32767. When V is set, the destination still receives the quotient's low 16 bits and the true remainder.
- R8: done is a one-cycle pulse. It rises after the 33rd rising edge that follows the edge accepting start when X is non-zero, and after the first such edge when X is zero. busy is high from acceptance until done.
- R9: start is ignored while busy is high, and start with opcode 3 is ignored at any time. Neither produces a result, and neither disturbs the result in flight.
- R10: The write enables dWe, xWe, yWe and nzvWe are 0 in every cycle in which done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; accepted when idle |
| op | input | 2 | 0 signed 16/16, 1 unsigned 32/16, 2 signed 32/16, 3 none |
| dIn | input | 16 | Register D operand |
| xIn | input | 16 | Register X operand (divisor) |
| yIn | input | 16 | Register Y operand (dividend high half) |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result strobe |
| dOut | output | 16 | New D value (remainder) |
| xOut | output | 16 | New X value (16/16 quotient) |
| yOut | output | 16 | New Y value (32/16 quotient) |
| dWe | output | 1 | Write D this cycle |
| xWe | output | 1 | Write X this cycle |
| yWe | output | 1 | Write Y this cycle |
| nzvWe | output | 1 | Update N, Z and V this cycle |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag (divide by zero) |

## Verification
A result with a non-zero divisor is due exactly 33 cycles after the accepting edge, and a divide-by-zero result is due after one cycle. The driver records the accepting cycle number and queues the expected cycle together with the expected registers and flags. The monitor samples on the falling edge. When done is high it compares both the arrival cycle and the contents against the head of the queue. A done that arrives with an empty queue, such as one caused by an ignored start, is reported as a failure.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16 = 2'd0,
    OP_UDIV32 = 2'd1,
    OP_SDIV32 = 2'd2,
    OP_NONE   = 2'd3
  } divOp_e;

  typedef struct packed {
    logic load;    // capture operands
    logic step;    // one quotient bit
    logic finish;  // sign fix-up and write-back
  } divStb_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import xdiv_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       zeroIn,
  output divStb_t    stb,
  output logic       busy,
  output logic       done
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  typedef enum logic [1:0] {IDLE_S, ITER_S, FIN_S} state_e;
  state_e state, nextState;
  logic [CW-1:0] count;
  logic accept;

  assign accept = (state == IDLE_S) && start && (op != OP_NONE);
  assign busy   = (state != IDLE_S);

  always_comb begin
    nextState = state;
    stb = '0;
    case (state)
      IDLE_S: if (accept) begin
        stb.load = 1'b1;
        nextState = zeroIn ? FIN_S : ITER_S;
      end
      ITER_S: begin
        stb.step = 1'b1;
        if (count == LAST) nextState = FIN_S;
      end
      FIN_S: begin
        stb.finish = 1'b1;
        nextState = IDLE_S;
      end
      default: nextState = IDLE_S;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE_S;
      count <= '0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == FIN_S);
      if (stb.load)      count <= '0;
      else if (stb.step) count <= count + 1'b1;
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ITER_S && start) |=> busy);

  // R8
  iter_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ITER_S && count != LAST) |=> state == ITER_S);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import xdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  divStb_t      stb,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic         zeroIn,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         dWe,
  output logic         xWe,
  output logic         yWe,
  output logic         nzvWe,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] MAG_NEG = DW'(1) << (W - 1);
  localparam logic [DW-1:0] MAG_POS = MAG_NEG - 1'b1;

  // operand preparation
  logic [DW-1:0] full, dvdMag;
  logic [W-1:0]  dsrMagIn;
  logic          dvdNeg, dsrNeg;

  assign zeroIn = (xIn == '0);
  assign full   = {yIn, dIn};

  always_comb begin
    dvdNeg = 1'b0;
    dvdMag = full;
    case (op)
      OP_SDIV16: begin
        dvdNeg = dIn[W-1];
        dvdMag = {{W{1'b0}}, (dIn[W-1] ? (~dIn + 1'b1) : dIn)};
      end
      OP_SDIV32: begin
        dvdNeg = full[DW-1];
        dvdMag = full[DW-1] ? (~full + 1'b1) : full;
      end
      default: ;
    endcase
    dsrNeg   = (op != OP_UDIV32) && xIn[W-1];
    dsrMagIn = dsrNeg ? (~xIn + 1'b1) : xIn;
  end

  // iteration state
  logic [1:0]    opReg;
  logic          negQ, negR, zeroDiv;
  logic [W-1:0]  dsr, rem;
  logic [DW-1:0] quo;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;

  assign shifted = {rem, quo[DW-1]};
  assign diff    = {1'b0, shifted} - {2'b00, dsr};

  // result fix-up
  logic [DW-1:0] qSgn;
  logic [W-1:0]  rSgn;
  logic          over;

  always_comb begin
    qSgn = negQ ? (~quo + 1'b1) : quo;
    rSgn = negR ? (~rem + 1'b1) : rem;
    if (opReg == OP_UDIV32) over = |quo[DW-1:W];
    else                    over = negQ ? (quo > MAG_NEG) : (quo > MAG_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg <= OP_NONE; negQ <= 1'b0; negR <= 1'b0; zeroDiv <= 1'b0;
      dsr <= '0; rem <= '0; quo <= '0;
      dOut <= '0; xOut <= '0; yOut <= '0;
      dWe <= 1'b0; xWe <= 1'b0; yWe <= 1'b0; nzvWe <= 1'b0;
      flagN <= 1'b0; flagZ <= 1'b0; flagV <= 1'b0; flagC <= 1'b0;
    end else begin
      dWe <= 1'b0; xWe <= 1'b0; yWe <= 1'b0; nzvWe <= 1'b0;
      if (stb.load) begin
        opReg   <= op;
        negQ    <= dvdNeg ^ dsrNeg;
        negR    <= dvdNeg;
        zeroDiv <= zeroIn;
        dsr     <= dsrMagIn;
        quo     <= dvdMag;
        rem     <= '0;
      end else if (stb.step) begin
        quo <= {quo[DW-2:0], ~diff[W+1]};
        rem <= diff[W+1] ? shifted[W-1:0] : diff[W-1:0];
      end else if (stb.finish) begin
        flagC <= zeroDiv;
        if (!zeroDiv) begin
          nzvWe <= 1'b1;
          flagN <= qSgn[W-1];
          flagZ <= (quo == '0);
          flagV <= over;
          dWe   <= 1'b1;
          dOut  <= rSgn;
          if (opReg == OP_SDIV16) begin
            xWe  <= 1'b1;
            xOut <= qSgn[W-1:0];
          end else begin
            yWe  <= 1'b1;
            yOut <= qSgn[W-1:0];
          end
        end
      end
    end
  end

  // R2 restoring invariant: partial remainder stays below the divisor
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |-> (rem < dsr));

  // R4
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |-> !zeroDiv);
endmodule

// File: rtl/ext_divider.sv
module ext_divider
  import xdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         dWe,
  output logic         xWe,
  output logic         yWe,
  output logic         nzvWe,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);
  localparam int ITERS = 2 * W;

  divStb_t stb;
  logic    zeroIn;

  div_ctrl #(.ITERS(ITERS)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .zeroIn(zeroIn),
    .stb(stb), .busy(busy), .done(done)
  );

  div_datapath #(.W(W)) uPath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn), .zeroIn(zeroIn),
    .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .dWe(dWe), .xWe(xWe), .yWe(yWe), .nzvWe(nzvWe),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(dWe || xWe || yWe || nzvWe));

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flagC) |-> !(dWe || xWe || yWe || nzvWe));

  // R1
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flagC) |-> (dWe && nzvWe && (xWe != yWe)));
endmodule

// File: tb/tb_ext_divider.sv
module tb_ext_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [15:0] dIn = '0, xIn = '0, yIn = '0;
  logic busy, done, dWe, xWe, yWe, nzvWe, flagN, flagZ, flagV, flagC;
  logic [15:0] dOut, xOut, yOut;

  ext_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn), .busy(busy), .done(done),
    .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .dWe(dWe), .xWe(xWe), .yWe(yWe), .nzvWe(nzvWe),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  typedef struct {
    int cycDue;
    logic [1:0] op;
    bit zero;
    logic [15:0] q, r;
    bit n, z, v;
  } exp_t;
  exp_t sb[$];

  function automatic string opTag(input logic [1:0] o);
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic exp_t model(input logic [1:0] o, input logic [15:0] d, x, y);
    exp_t e;
    longint a, b, q, r;
    e.op = o; e.cycDue = 0;
    e.q = '0; e.r = '0; e.n = 0; e.z = 0; e.v = 0;
    e.zero = (x == 16'h0);
    case (o)
      2'd0: begin a = longint'($signed(d)); b = longint'($signed(x)); end
      2'd1: begin a = longint'({32'h0, y, d}); b = longint'({48'h0, x}); end
      default: begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
    endcase
    if (!e.zero) begin
      q = a / b;
      r = a % b;
      e.q = q[15:0];
      e.r = r[15:0];
      e.n = q[15];
      e.z = (q == 0);
      if (o == 2'd1) e.v = (q > 65535);
      else           e.v = (q > 32767) || (q < -32768);
    end
    return e;
  endfunction

  // driver: waits for idle, issues one divide and queues its expectation
  task automatic issue(input logic [1:0] o, input logic [15:0] d, x, y);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = o; dIn = d; xIn = x; yIn = y;
    e = model(o, d, x, y);
    @(posedge clk);
    #1;
    e.cycDue = cyc + (e.zero ? 1 : 33);  // R8 latency
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = opTag(e.op);
        check(cyc == e.cycDue, "R8", "done cycle", cyc, e.cycDue);
        check(flagC == e.zero, e.zero ? "R4" : "R5", "flagC", flagC, e.zero);
        if (e.zero) begin
          check(!(dWe || xWe || yWe || nzvWe), "R4", "write enables",
                {dWe, xWe, yWe, nzvWe}, 0);
        end else begin
          check(dWe && nzvWe, t, "dWe/nzvWe", {dWe, nzvWe}, 2'b11);
          check(dOut == e.r, t, "remainder", dOut, e.r);
          if (e.op == 2'd0) begin
            check(xWe && !yWe, "R1", "x/y enables", {xWe, yWe}, 2'b10);
            check(xOut == e.q, "R1", "quotient", xOut, e.q);
          end else begin
            check(yWe && !xWe, t, "x/y enables", {xWe, yWe}, 2'b01);
            check(yOut == e.q, t, "quotient", yOut, e.q);
          end
          check(flagN == e.n, "R5", "flagN", flagN, e.n);
          check(flagZ == e.z, "R5", "flagZ", flagZ, e.z);
          check(flagV == e.v, (e.op == 2'd1) ? "R6" : "R7", "flagV", flagV, e.v);
        end
      end
    end else if (rst_n) begin
      if (dWe || xWe || yWe || nzvWe)
        check(1'b0, "R10", "enable without done", {dWe, xWe, yWe, nzvWe}, 0);
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] corners [5];
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h0001; corners[4] = 16'h7FFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R8", "busy after reset", busy, 0);
    check(done == 0, "R8", "done after reset", done, 0);
    check({dWe, xWe, yWe, nzvWe} == 0, "R10", "enables after reset",
          {dWe, xWe, yWe, nzvWe}, 0);

    // directed signs and truncation, R1 and R3
    issue(2'd0, 16'hFFF9, 16'h0002, 16'h0);   // -7/2 -> -3 r -1
    issue(2'd0, 16'h0007, 16'hFFFE, 16'h0);   // 7/-2 -> -3 r 1
    issue(2'd0, 16'h8000, 16'hFFFF, 16'h0);   // overflow, R7
    issue(2'd2, 16'h0000, 16'h0002, 16'hFFFF); // -65536/2, R7
    issue(2'd2, 16'h0001, 16'hFFFF, 16'h8000); // huge / -1, R7
    issue(2'd1, 16'hFFFF, 16'h0001, 16'hFFFF); // R6 overflow
    issue(2'd1, 16'h1234, 16'h0000, 16'h5678); // R4 zero divisor
    issue(2'd1, 16'h0005, 16'h0009, 16'h0000); // R5 zero quotient

    // R9: start while busy is ignored
    issue(2'd1, 16'h4321, 16'h0123, 16'h0042);
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'd0; dIn = 16'h0009; xIn = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1, "R9", "busy kept", busy, 1);

    // R9: opcode 3 ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = 2'd3; dIn = 16'h0010; xIn = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(busy == 0, "R9", "opcode 3 busy", busy, 0);
      @(negedge clk);
    end

    // corner sweep over every opcode
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 5; k++)
            issue(2'(o), corners[i], corners[j], corners[k]);

    // random operands
    for (int n = 0; n < 300; n++) begin
      logic [15:0] rd, rx, ry;
      rd = 16'($urandom);
      rx = 16'($urandom);
      ry = 16'($urandom);
      if (n % 4 == 0) rx = {12'h0, 4'($urandom)};
      issue(2'(n % 3), rd, rx, ry);
    end

    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8", "results outstanding", sb.size(), 0);
    finishRun();
  end
endmodule